// File: doc/BRIEF.md
# Dual-Protocol Serial Register Port

This block lets an external host reach a bank of eight byte-wide registers over either an I2C or an SPI link, using one shared set of pins. The level of the chip-select input decides the protocol at run time: high selects I2C, low selects SPI. The block is always the target of a transfer, so the serial clock is only ever an input. The data pin carries I2C data in one mode and SPI data-in in the other. In I2C mode the block pulls the data line low through an output enable and never drives it high.

The port turns serial traffic into single-cycle read and write strobes with a 3-bit register address and an 8-bit data byte. The register bank itself sits outside the block and returns read data on a byte-wide input. A parameter mask marks some addresses as read-only. Writes to those addresses never produce a write strobe. Reads from them return whatever the outside bank presents at that moment, so they show live status.

Top module: `dual_serial_regport`

## Requirements
- R1: While chip-select is high, the SPI output enable stays low. While chip-select is low, the I2C data output enable stays low. Only the protocol that chip-select selects responds.
- R2: A falling data edge while the clock is high is a START. A rising data edge while the clock is high is a STOP. After a STOP, no byte is acknowledged until a new START. A repeated START restarts the address phase.
- R3: After START, the first byte is a 7-bit device address (bits 7:1) and a read flag (bit 0, 1 = read). On a match with DEV_ADDR (default 7'h2A), the block pulls data low during the ninth clock. On a mismatch, the block stays silent and issues no strobe until the next START.
- R4: In an I2C write, the byte after the address loads the register pointer from its bits 2:0. Each later byte is written to the pointer with a one-cycle write strobe, and the pointer then advances modulo 8. Every byte is acknowledged.
- R5: In an I2C read, the block sends the register at the pointer, MSB first, and the pointer advances after each byte. A master acknowledge (data low on the ninth clock) fetches the next byte. A master not-acknowledge ends the read.
- R6: The I2C data output enable changes only while the serial clock is low.
- R7: In SPI (mode 0, MSB first, data sampled on the rising clock edge), the first byte is a command. Bit 7 is the read flag (1 = read) and bits 2:0 are the start address. In a write, each later byte is written to the current address, and the address then advances modulo 8.
- R8: In an SPI read, the first data bit is on the output before the ninth rising clock edge. Later bits change on falling edges. Successive bytes come from successive addresses.
- R9: A write to an address whose bit is set in RO_MASK (default 8'hC0, addresses 6 and 7) gives no write strobe and is still acknowledged. A read from such an address returns the read-data input as it stands at that time.
- R10: Pulling chip-select low during an I2C transfer aborts it. After chip-select returns high, the I2C side acknowledges nothing until a new START.
- R11: During and right after reset, both output enables are low and no strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | I2C data line level, or SPI data-in |
| cs_n_i | input | 1 | Chip select; high selects I2C, low selects SPI |
| sda_oe_o | output | 1 | Pulls the I2C data line low when high |
| miso_o | output | 1 | SPI serial data out |
| miso_oe_o | output | 1 | SPI data-out enable |
| reg_wr_o | output | 1 | One-cycle register write strobe |
| reg_rd_o | output | 1 | One-cycle register read strobe |
| reg_addr_o | output | 3 | Register address for the strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data from the register bank, addressed by reg_addr_o |

## Verification
The hardest case to reach from the pins is a protocol switch in the middle of a byte. This leaves the I2C side part-way through its bit count with the pointer loaded. Only the later behaviour of the shared pins shows whether it recovered. The stimulus starts an I2C write, loads the pointer, and clocks half a data byte. It then pulls chip-select low and raises it again, and finishes the byte and clocks another. It expects no acknowledge and no write strobe until a fresh START runs a clean transfer. A per-clock reference model holds the expected write sequence and register contents, so any stray strobe during such a switch is caught on the cycle it appears.

// File: rtl/sbr_pkg.sv
// Package: shared widths and types for the dual-protocol register port.
// Assumes an 8-bit data path and a power-of-two register count.
package sbr_pkg;

    localparam int REG_AW = 3;
    localparam int REG_DW = 8;
    localparam int NREGS  = 1 << REG_AW;
    localparam int BIT_CW = $clog2(REG_DW);

    // One register access request from a protocol engine
    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [REG_AW-1:0] addr;
        logic [REG_DW-1:0] wdata;
    } reg_req_t;

    typedef enum logic [2:0] {
        I2C_IDLE,
        I2C_RX,
        I2C_ACK,
        I2C_TX,
        I2C_MACK,
        I2C_HOLD
    } i2c_state_t;

    typedef enum logic [1:0] {
        RX_DEVADDR,
        RX_POINTER,
        RX_WDATA
    } rx_kind_t;

endpackage

// File: rtl/sbr_sync.sv
// Module: two-flop synchronizer, one chain per bit.
// Assumes inputs are asynchronous single-bit levels; no bus coherency is implied.
module sbr_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, stab_q;

        // Two-stage capture of one asynchronous input bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end

        assign q[i] = stab_q;
    end

endmodule

// File: rtl/sbr_i2c_engine.sv
// Module: I2C target engine. Detects START/STOP, matches a 7-bit device
// address, loads a register pointer, issues write strobes, and serves read
// bytes with pointer auto-increment.
// Assumes synchronized SCL/SDA and a system clock many times the SCL rate.
// Read data is captured one cycle after the read strobe, with the address held.
module sbr_i2c_engine
    import sbr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              scl,
    input  logic              sda,
    input  logic [REG_DW-1:0] rdata,
    output reg_req_t          req,
    output logic              sda_oe
);

    logic              scl_q, sda_q;
    i2c_state_t        state;
    rx_kind_t          kind;
    logic [BIT_CW-1:0] bit_cnt;
    logic              byte_full, rw_q, acked, load_pend;
    logic [REG_DW-1:0] rx_sh, tx_sh;
    logic [REG_AW-1:0] ptr;

    wire scl_rise  = scl & ~scl_q;
    wire scl_fall  = ~scl & scl_q;
    wire start_det = en & scl & scl_q & sda_q & ~sda;
    wire stop_det  = en & scl & scl_q & ~sda_q & sda;

    // Protocol sequencer: bit shifting, acknowledge and strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
            state     <= I2C_IDLE;
            kind      <= RX_DEVADDR;
            bit_cnt   <= '0;
            byte_full <= 1'b0;
            rw_q      <= 1'b0;
            acked     <= 1'b0;
            load_pend <= 1'b0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ptr       <= '0;
            req       <= '0;
            sda_oe    <= 1'b0;
        end else begin
            scl_q  <= scl;
            sda_q  <= sda;
            req.wr <= 1'b0;
            req.rd <= 1'b0;
            if (!en) begin
                state     <= I2C_IDLE;
                bit_cnt   <= '0;
                byte_full <= 1'b0;
                load_pend <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (start_det) begin
                state     <= I2C_RX;
                kind      <= RX_DEVADDR;
                bit_cnt   <= '0;
                byte_full <= 1'b0;
                load_pend <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (stop_det) begin
                state     <= I2C_IDLE;
                load_pend <= 1'b0;
                sda_oe    <= 1'b0;
            end else begin
                if (load_pend) begin
                    load_pend <= 1'b0;
                    tx_sh     <= rdata;
                    sda_oe    <= ~rdata[REG_DW-1];
                end
                case (state)
                    I2C_RX: begin
                        if (scl_rise) begin
                            rx_sh   <= {rx_sh[REG_DW-2:0], sda};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == BIT_CW'(REG_DW - 1)) byte_full <= 1'b1;
                        end else if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            bit_cnt   <= '0;
                            case (kind)
                                RX_DEVADDR: begin
                                    if (rx_sh[REG_DW-1:1] == DEV_ADDR) begin
                                        rw_q   <= rx_sh[0];
                                        sda_oe <= 1'b1;
                                        state  <= I2C_ACK;
                                    end else begin
                                        state  <= I2C_HOLD;
                                    end
                                end
                                RX_POINTER: begin
                                    ptr    <= rx_sh[REG_AW-1:0];
                                    sda_oe <= 1'b1;
                                    state  <= I2C_ACK;
                                end
                                default: begin
                                    req.wr    <= 1'b1;
                                    req.addr  <= ptr;
                                    req.wdata <= rx_sh;
                                    ptr       <= ptr + 1'b1;
                                    sda_oe    <= 1'b1;
                                    state     <= I2C_ACK;
                                end
                            endcase
                        end
                    end
                    I2C_ACK: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            if (kind == RX_DEVADDR && rw_q) begin
                                req.rd    <= 1'b1;
                                req.addr  <= ptr;
                                ptr       <= ptr + 1'b1;
                                load_pend <= 1'b1;
                                state     <= I2C_TX;
                            end else begin
                                kind  <= (kind == RX_DEVADDR) ? RX_POINTER : RX_WDATA;
                                state <= I2C_RX;
                            end
                        end
                    end
                    I2C_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == BIT_CW'(REG_DW - 1)) begin
                                sda_oe  <= 1'b0;
                                bit_cnt <= '0;
                                state   <= I2C_MACK;
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                                tx_sh   <= {tx_sh[REG_DW-2:0], 1'b0};
                                sda_oe  <= ~tx_sh[REG_DW-2];
                            end
                        end
                    end
                    I2C_MACK: begin
                        if (scl_rise) begin
                            acked <= ~sda;
                        end else if (scl_fall) begin
                            if (acked) begin
                                req.rd    <= 1'b1;
                                req.addr  <= ptr;
                                ptr       <= ptr + 1'b1;
                                load_pend <= 1'b1;
                                state     <= I2C_TX;
                            end else begin
                                state <= I2C_HOLD;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sbr_spi_engine.sv
// Module: SPI mode-0 target engine. Receives a command byte (read flag in
// bit 7, address in the low bits), then writes or reads a run of bytes
// with address auto-increment, MSB first.
// Assumes synchronized SCL/MOSI; the enable input is the inverted chip select.
module sbr_spi_engine
    import sbr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              scl,
    input  logic              mosi,
    input  logic [REG_DW-1:0] rdata,
    output reg_req_t          req,
    output logic              miso,
    output logic              miso_oe
);

    logic              scl_q, cmd_done, is_read, load_pend;
    logic [BIT_CW-1:0] bit_cnt;
    logic [REG_DW-1:0] rx_sh, tx_sh;
    logic [REG_AW-1:0] ptr;
    logic [REG_DW-1:0] rx_next;

    wire scl_rise = scl & ~scl_q;
    wire scl_fall = ~scl & scl_q;

    // Byte being completed on this rising edge
    always_comb rx_next = {rx_sh[REG_DW-2:0], mosi};

    // Frame sequencer: command decode, strobes and output shifting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q     <= 1'b0;
            cmd_done  <= 1'b0;
            is_read   <= 1'b0;
            load_pend <= 1'b0;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ptr       <= '0;
            req       <= '0;
            miso_oe   <= 1'b0;
        end else begin
            scl_q  <= scl;
            req.wr <= 1'b0;
            req.rd <= 1'b0;
            if (!en) begin
                cmd_done  <= 1'b0;
                is_read   <= 1'b0;
                load_pend <= 1'b0;
                bit_cnt   <= '0;
                tx_sh     <= '0;
                miso_oe   <= 1'b0;
            end else begin
                miso_oe <= 1'b1;
                if (load_pend) begin
                    load_pend <= 1'b0;
                    tx_sh     <= rdata;
                end
                if (scl_rise) begin
                    rx_sh   <= rx_next;
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == BIT_CW'(REG_DW - 1)) begin
                        if (!cmd_done) begin
                            cmd_done <= 1'b1;
                            is_read  <= rx_next[REG_DW-1];
                            ptr      <= rx_next[REG_AW-1:0];
                            if (rx_next[REG_DW-1]) begin
                                req.rd    <= 1'b1;
                                req.addr  <= rx_next[REG_AW-1:0];
                                ptr       <= rx_next[REG_AW-1:0] + 1'b1;
                                load_pend <= 1'b1;
                            end
                        end else if (is_read) begin
                            req.rd    <= 1'b1;
                            req.addr  <= ptr;
                            ptr       <= ptr + 1'b1;
                            load_pend <= 1'b1;
                        end else begin
                            req.wr    <= 1'b1;
                            req.addr  <= ptr;
                            req.wdata <= rx_next;
                            ptr       <= ptr + 1'b1;
                        end
                    end
                end else if (scl_fall && bit_cnt != '0) begin
                    tx_sh <= {tx_sh[REG_DW-2:0], 1'b0};
                end
            end
        end
    end

    assign miso = tx_sh[REG_DW-1];

endmodule

// File: rtl/dual_serial_regport.sv
// Module: top of the dual-protocol register port. Synchronizes the pins,
// runs the I2C and SPI engines side by side (only the one picked by
// chip-select is enabled) and merges their requests into one strobe bus.
// Assumes the register bank decodes reg_addr_o combinationally for reads.
module dual_serial_regport
    import sbr_pkg::*;
#(
    parameter logic [6:0]       DEV_ADDR = 7'h2A,
    parameter logic [NREGS-1:0] RO_MASK  = 8'hC0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              cs_n_i,
    output logic              sda_oe_o,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    output logic [REG_AW-1:0] reg_addr_o,
    output logic [REG_DW-1:0] reg_wdata_o,
    input  logic [REG_DW-1:0] reg_rdata_i
);

    logic [2:0] pins_s;
    logic       cs_s, scl_s, sda_s;
    reg_req_t   i2c_req, spi_req, act_req;

    sbr_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n_i, scl_i, sda_i}),
        .q     (pins_s)
    );

    assign {cs_s, scl_s, sda_s} = pins_s;

    sbr_i2c_engine #(.DEV_ADDR(DEV_ADDR)) u_i2c (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (cs_s),
        .scl    (scl_s),
        .sda    (sda_s),
        .rdata  (reg_rdata_i),
        .req    (i2c_req),
        .sda_oe (sda_oe_o)
    );

    sbr_spi_engine u_spi (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (~cs_s),
        .scl     (scl_s),
        .mosi    (sda_s),
        .rdata   (reg_rdata_i),
        .req     (spi_req),
        .miso    (miso_o),
        .miso_oe (miso_oe_o)
    );

    // Pick the request of the engine that chip-select enables
    always_comb act_req = cs_s ? i2c_req : spi_req;

    // Drop write strobes aimed at read-only addresses
    always_comb begin
        reg_wr_o    = act_req.wr & ~RO_MASK[act_req.addr];
        reg_rd_o    = act_req.rd;
        reg_addr_o  = act_req.addr;
        reg_wdata_o = act_req.wdata;
    end

endmodule

// File: rtl/dual_serial_regport_chk.sv
// Module: property checker for dual_serial_regport, attached by bind.
// Assumes the two-flop pin synchronizer latency of the top module.
module dual_serial_regport_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic cs_n_i,
    input logic sda_oe_o,
    input logic miso_oe_o,
    input logic reg_wr_o,
    input logic reg_rd_o
);

    logic started, rst_q;

    // Track the first edge and the previous reset level
    always_ff @(posedge clk) begin
        started <= 1'b1;
        rst_q   <= rst_n;
        if (started && !rst_q) begin
            assert_quiet_after_reset_R11: assert (!sda_oe_o && !miso_oe_o && !reg_wr_o && !reg_rd_o)
                else $error("outputs active after reset");
        end
    end

    assert_sda_quiet_spi_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_i && !$past(cs_n_i) && !$past(cs_n_i, 2) && !$past(cs_n_i, 3)) |-> !sda_oe_o);

    assert_miso_off_i2c_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !miso_oe_o);

    assert_sda_steady_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3) && $past(cs_n_i, 4) &&
         scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3) && $past(scl_i, 4))
        |-> $stable(sda_oe_o));

    assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    assert_rd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_o |=> !reg_rd_o);

endmodule

bind dual_serial_regport dual_serial_regport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .cs_n_i    (cs_n_i),
    .sda_oe_o  (sda_oe_o),
    .miso_oe_o (miso_oe_o),
    .reg_wr_o  (reg_wr_o),
    .reg_rd_o  (reg_rd_o)
);

// File: tb/dual_serial_regport_bench.sv
// Bench: drives I2C and SPI transfers on shared pins, models the register
// bank and the expected write sequence, and compares on every clock.
module dual_serial_regport_bench;

    localparam int H     = 8;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl, sda_drv, cs_n;
    logic       sda_oe, miso, miso_oe, reg_wr, reg_rd;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sda_line;

    logic [7:0]  mem     [8];
    logic [7:0]  exp_mem [8];
    logic [10:0] expq    [$];
    logic [7:0]  status;
    int checks = 0, fails = 0, cyc = 0, cs_low_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_drv & ~sda_oe;

    // Register bank model: RO addresses 6 and 7 show live status
    always_comb begin
        if (reg_addr == 3'd6)      reg_rdata = status;
        else if (reg_addr == 3'd7) reg_rdata = ~status;
        else                       reg_rdata = mem[reg_addr];
    end

    dual_serial_regport u_dual_serial_regport (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .cs_n_i      (cs_n),
        .sda_oe_o    (sda_oe),
        .miso_o      (miso),
        .miso_oe_o   (miso_oe),
        .reg_wr_o    (reg_wr),
        .reg_rd_o    (reg_rd),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_rdata_i (reg_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic bit is_ro(input logic [2:0] a);
        return (a == 3'd6) || (a == 3'd7);
    endfunction

    task automatic expect_write(input logic [2:0] a, input logic [7:0] d);
        if (!is_ro(a)) begin
            exp_mem[a] = d;
            expq.push_back({a, d});
        end
    endtask

    // Per-clock comparison against the expected write sequence
    always @(negedge clk) begin
        cyc++;
        cs_low_cnt = cs_n ? 0 : cs_low_cnt + 1;
        if (rst_n) begin
            if (reg_wr) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R9/R10 unexpected write", {reg_addr, reg_wdata}, 11'h0);
                end else begin
                    logic [10:0] e;
                    e = expq.pop_front();
                    check({reg_addr, reg_wdata} == e, "R4/R7 write order", {reg_addr, reg_wdata}, e);
                end
                mem[reg_addr] = reg_wdata;
            end
            if (cs_low_cnt > 6)
                check(!sda_oe, "R1 sda_oe low in SPI", {10'd0, sda_oe}, 11'd0);
        end
    end

    // I2C bit: set data, raise clock, sample mid-high, lower clock
    task automatic clk_bit(input logic b, output logic s);
        sda_drv = b;
        wait_clks(H);
        scl = 1'b1;
        wait_clks(H / 2);
        s = sda_line;
        wait_clks(H / 2);
        scl = 1'b0;
        wait_clks(2);
    endtask

    task automatic i2c_start();
        sda_drv = 1'b1;
        wait_clks(H);
        scl = 1'b1;
        wait_clks(H);
        sda_drv = 1'b0;
        wait_clks(H);
        scl = 1'b0;
        wait_clks(H);
    endtask

    task automatic i2c_stop();
        sda_drv = 1'b0;
        wait_clks(H);
        scl = 1'b1;
        wait_clks(H);
        sda_drv = 1'b1;
        wait_clks(H);
    endtask

    task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic i2c_rbyte(input logic mack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clk_bit(~mack, s);
    endtask

    // SPI mode 0 byte: master samples miso just before each rising edge
    task automatic spi_byte(input logic [7:0] b, output logic [7:0] r);
        r = '0;
        for (int i = 7; i >= 0; i--) begin
            sda_drv = b[i];
            wait_clks(H);
            r = {r[6:0], miso};
            scl = 1'b1;
            wait_clks(H);
            scl = 1'b0;
            wait_clks(2);
        end
    endtask

    task automatic i2c_set_ptr(input logic [2:0] p);
        logic ack;
        i2c_start();
        i2c_wbyte(8'h54, ack);
        check(ack, "R3 address ack", {10'd0, ack}, 11'd1);
        i2c_wbyte({5'd0, p}, ack);
        check(ack, "R4 pointer ack", {10'd0, ack}, 11'd1);
    endtask

    initial begin
        logic       ack;
        logic [7:0] d, r;
        scl = 1'b1; sda_drv = 1'b1; cs_n = 1'b1; rst_n = 1'b0; status = 8'h5C;
        for (int i = 0; i < 8; i++) begin mem[i] = '0; exp_mem[i] = '0; end
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(1);
        // R11: quiet after reset
        check(!sda_oe && !miso_oe && !reg_wr && !reg_rd, "R11 reset state",
              {7'd0, sda_oe, miso_oe, reg_wr, reg_rd}, 11'd0);
        wait_clks(H);

        // R4: pointer 2, three bytes
        i2c_set_ptr(3'd2);
        expect_write(3'd2, 8'hA1); i2c_wbyte(8'hA1, ack); check(ack, "R4 data ack", {10'd0, ack}, 11'd1);
        expect_write(3'd3, 8'hB2); i2c_wbyte(8'hB2, ack); check(ack, "R4 data ack", {10'd0, ack}, 11'd1);
        expect_write(3'd4, 8'hC3); i2c_wbyte(8'hC3, ack); check(ack, "R4 data ack", {10'd0, ack}, 11'd1);
        check(!miso_oe, "R1 miso_oe low in I2C", {10'd0, miso_oe}, 11'd0);
        i2c_stop();

        // R9 + R4 wrap: writes to 6,7 dropped, 0 written
        i2c_set_ptr(3'd6);
        expect_write(3'd6, 8'h11); i2c_wbyte(8'h11, ack); check(ack, "R9 RO write acked", {10'd0, ack}, 11'd1);
        expect_write(3'd7, 8'h22); i2c_wbyte(8'h22, ack); check(ack, "R9 RO write acked", {10'd0, ack}, 11'd1);
        expect_write(3'd0, 8'h33); i2c_wbyte(8'h33, ack); check(ack, "R4 wrap ack", {10'd0, ack}, 11'd1);
        i2c_stop();

        // R5 + R2: repeated start into a read of three bytes
        i2c_set_ptr(3'd2);
        i2c_start();
        i2c_wbyte(8'h55, ack); check(ack, "R2 repeated start ack", {10'd0, ack}, 11'd1);
        i2c_rbyte(1'b1, d); check(d == exp_mem[2], "R5 read byte", {3'd0, d}, {3'd0, exp_mem[2]});
        i2c_rbyte(1'b1, d); check(d == exp_mem[3], "R5 read byte", {3'd0, d}, {3'd0, exp_mem[3]});
        i2c_rbyte(1'b0, d); check(d == exp_mem[4], "R5 read byte", {3'd0, d}, {3'd0, exp_mem[4]});
        i2c_stop();
        check(mem[6] == 8'h00 && mem[7] == 8'h00, "R9 RO contents kept", {3'd0, mem[6]}, 11'd0);

        // R3: wrong address gets no ack and no writes
        i2c_start();
        i2c_wbyte(8'h2A, ack); check(!ack, "R3 mismatch nack", {10'd0, ack}, 11'd0);
        i2c_wbyte(8'h01, ack); check(!ack, "R3 silent after mismatch", {10'd0, ack}, 11'd0);
        i2c_wbyte(8'hEE, ack);
        i2c_stop();

        // R2: after STOP, no ack without a new START
        i2c_wbyte(8'h54, ack); check(!ack, "R2 no ack after stop", {10'd0, ack}, 11'd0);
        i2c_stop();

        // R9: live status on RO reads
        i2c_set_ptr(3'd6);
        i2c_start();
        i2c_wbyte(8'h55, ack);
        i2c_rbyte(1'b1, d); check(d == 8'h5C, "R9 live status", {3'd0, d}, 11'h05C);
        i2c_rbyte(1'b0, d); check(d == 8'hA3, "R9 live status", {3'd0, d}, 11'h0A3);
        i2c_stop();
        status = 8'h77;
        i2c_set_ptr(3'd6);
        i2c_start();
        i2c_wbyte(8'h55, ack);
        i2c_rbyte(1'b0, d); check(d == 8'h77, "R9 status follows input", {3'd0, d}, 11'h077);
        i2c_stop();

        // R7: SPI write of two bytes from address 1
        scl = 1'b0; wait_clks(H);
        cs_n = 1'b0; wait_clks(H);
        spi_byte(8'h01, r);
        check(miso_oe, "R1 miso_oe high in SPI", {10'd0, miso_oe}, 11'd1);
        expect_write(3'd1, 8'h44); spi_byte(8'h44, r);
        expect_write(3'd2, 8'h55); spi_byte(8'h55, r);
        wait_clks(H); cs_n = 1'b1; wait_clks(2 * H);

        // R8: SPI read of three bytes from address 1
        cs_n = 1'b0; wait_clks(H);
        spi_byte(8'h81, r);
        spi_byte(8'h00, r); check(r == exp_mem[1], "R8 SPI read", {3'd0, r}, {3'd0, exp_mem[1]});
        spi_byte(8'h00, r); check(r == exp_mem[2], "R8 SPI read", {3'd0, r}, {3'd0, exp_mem[2]});
        spi_byte(8'h00, r); check(r == exp_mem[3], "R8 SPI read", {3'd0, r}, {3'd0, exp_mem[3]});
        wait_clks(H); cs_n = 1'b1; wait_clks(2 * H);

        // R7 + R9: SPI write at address 7 dropped, wraps to 0
        cs_n = 1'b0; wait_clks(H);
        spi_byte(8'h07, r);
        expect_write(3'd7, 8'h99); spi_byte(8'h99, r);
        expect_write(3'd0, 8'h88); spi_byte(8'h88, r);
        wait_clks(H); cs_n = 1'b1; wait_clks(2 * H);
        scl = 1'b1; wait_clks(2 * H);

        // R10: chip-select pulse in mid-byte aborts the I2C write
        i2c_set_ptr(3'd5);
        for (int i = 0; i < 4; i++) clk_bit(1'b1, ack);
        cs_n = 1'b0; wait_clks(12);
        cs_n = 1'b1; wait_clks(12);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, ack);
        clk_bit(1'b1, ack);
        check(ack, "R10 no ack after abort", {10'd0, ~ack}, 11'd0);
        i2c_wbyte(8'h3C, ack); check(!ack, "R10 still silent", {10'd0, ack}, 11'd0);
        i2c_stop();
        i2c_set_ptr(3'd5);
        expect_write(3'd5, 8'h6D); i2c_wbyte(8'h6D, ack); check(ack, "R10 recovers on START", {10'd0, ack}, 11'd1);
        i2c_stop();

        wait_clks(4 * H);
        check(expq.size() == 0, "R4/R7 all writes seen", 11'(expq.size()), 11'd0);
        check(mem[5] == 8'h6D && mem[0] == 8'h88, "R7 bank contents", {3'd0, mem[0]}, 11'h088);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        wait (cyc >= LIMIT);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual %0d expected below %0d", cyc, LIMIT);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule